// File: doc/BRIEF.md
# Byte-Wide Link Port Transmitter

This block sends 32-bit words across a narrow parallel link. The link has eight data lines, a strobe clock driven by this side, and an acknowledge line driven by the far side. Words enter through a valid/ready handshake into a small internal buffer. Each buffered word is cut into four bytes, least significant byte first. Every byte is marked by one low pulse of the link clock, and the receiver latches the byte on the falling edge. The length of the clock phases is set by a programmable divider of the system clock. Between words the link clock rests high.

Flow control works per word. The acknowledge input passes through a two-flop synchronizer and is examined only when a new word is about to begin. While acknowledge is low, no new word starts. A word that is already going out always completes, even if acknowledge drops partway through it. An absent receiver leaves acknowledge pulled low, so the transmitter simply waits.

The block also drives the output enables of the data and clock pads. Both pads are released (high impedance) while the port is disabled. Acknowledge is only ever an input here.

Top module: `lnk8_word_tx`

## Requirements
- R1: In the cycle after synchronous reset is released, `in_ready` is 1, `lnk_clk_o` is 1, `lnk_data_o` is 0 and both pad enables are 0.
- R2: `lnk_data_oe` and `lnk_clk_oe` both equal `cfg_en` as registered one cycle earlier, so the data and clock pads float whenever the port is disabled.
- R3: Each word leaves as four bytes, byte k being bits [8k+7:8k], in order k = 0, 1, 2, 3. Each byte produces exactly one falling edge of `lnk_clk_o`. The byte is on `lnk_data_o` before that edge and does not change while the clock is low.
- R4: Each low phase of `lnk_clk_o` lasts `cfg_div`+1 clock cycles. Each byte's data is shown for `cfg_div`+1 cycles with the clock high before it falls. The clock is high whenever no word is in progress.
- R5: A new word starts only if the acknowledge input, delayed by the two synchronizer flops, is 1. After reset, acknowledge is treated as 0.
- R6: If acknowledge falls after a word has started, that word's remaining bytes are still sent. The next buffered word waits until acknowledge returns high.
- R7: The buffer holds 4 words and sends them in arrival order. `in_ready` is 0 exactly when 4 words are held. A word offered while `in_ready` is 0 is not taken and never appears on the link.
- R8: Clearing `cfg_en` in the middle of a word abandons the rest of that word, with no further falling edges. Words still in the buffer are kept and follow once the port is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Port enable for transmit |
| cfg_div | input | 8 | Clock phase length minus one, in system clock cycles |
| in_valid | input | 1 | Word offered on `in_data` |
| in_ready | output | 1 | Buffer has room for a word |
| in_data | input | 32 | Word to transmit |
| lnk_ack_i | input | 1 | Acknowledge from the receiver (asynchronous) |
| lnk_data_o | output | 8 | Data byte to the link pads |
| lnk_data_oe | output | 1 | Output enable of the data pads |
| lnk_clk_o | output | 1 | Link strobe clock |
| lnk_clk_oe | output | 1 | Output enable of the clock pad |

## Verification
On every cycle, the assertions check the following:
- the pad enables track the registered port enable;
- the data byte stays frozen while the link clock is low;
- every low phase has the programmed length;
- no word begins unless acknowledge was high two samples earlier;
- back-pressure appears exactly when a shadow count of stored words reaches the buffer depth.

Other behaviour shows up only in the bench's scenarios:
- byte order within a word and word order across the buffer;
- a word finishing after acknowledge drops mid-word while the next one stays parked;
- a refused word never appearing on the link;
- an abandoned word giving way to the next buffered one after re-enable.

// File: rtl/lnk_pkg.sv
package lnk_pkg;

  // serializer phases: resting, byte shown with clock high, clock low
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_LOW   = 2'd2
  } ser_st_e;

endpackage

// File: rtl/lnk_sync2.sv
module lnk_sync2 #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q <= {chain_q[STAGES-2:0], d};
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/lnk_obuf.sv
// Word buffer: memory without reset, registered read with write-first bypass
module lnk_obuf #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_valid,
  output logic         wr_ready,
  input  logic [W-1:0] wr_data,
  output logic         rd_avail,
  input  logic         rd_pop,
  output logic [W-1:0] rd_data
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q, rd_nxt;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  rd_q;
  logic          push, pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign wr_ready = (cnt_q != FULL_CNT);
  assign rd_avail = (cnt_q != '0);
  assign push     = wr_valid && wr_ready;
  assign pop      = rd_pop && rd_avail;
  assign rd_nxt   = pop ? step(rd_ptr_q) : rd_ptr_q;
  assign rd_data  = rd_q;

  always_ff @(posedge clk) begin
    if (push) begin
      mem[wr_ptr_q] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (push && (wr_ptr_q == rd_nxt)) begin
      rd_q <= wr_data;
    end else begin
      rd_q <= mem[rd_nxt];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      rd_ptr_q <= rd_nxt;
      if (push) begin
        wr_ptr_q <= step(wr_ptr_q);
      end
      unique case ({push, pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

endmodule

// File: rtl/lnk_ser.sv
// Word-to-byte serializer with strobe generation and per-word start gate
module lnk_ser
  import lnk_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LANE_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [DIV_W-1:0]  div,
  input  logic              ack_ok,
  input  logic              word_avail,
  input  logic [WORD_W-1:0] word_in,
  output logic              word_pop,
  output logic [LANE_W-1:0] lane_o,
  output logic              lclk_o
);

  localparam int NLANES = WORD_W / LANE_W;
  localparam int IW     = (NLANES > 1) ? $clog2(NLANES) : 1;

  ser_st_e           st_q;
  logic [DIV_W-1:0]  cnt_q;
  logic [IW-1:0]     idx_q, idx_nxt;
  logic [WORD_W-1:0] word_q;
  logic [LANE_W-1:0] lane_q;
  logic              lclk_q;
  logic              start, last_lane, cnt_done;
  logic [LANE_W-1:0] lanes [NLANES];

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    assign lanes[g] = word_q[g*LANE_W +: LANE_W];
  end

  assign start     = en && (st_q == ST_IDLE) && word_avail && ack_ok;
  assign last_lane = (idx_q == IW'(NLANES - 1));
  assign cnt_done  = (cnt_q == '0);
  assign idx_nxt   = idx_q + IW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      word_q <= '0;
      lane_q <= '0;
      lclk_q <= 1'b1;
    end else if (!en) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      lclk_q <= 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          lclk_q <= 1'b1;
          if (start) begin
            word_q <= word_in;
            lane_q <= word_in[LANE_W-1:0];
            idx_q  <= '0;
            cnt_q  <= div;
            st_q   <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (cnt_done) begin
            lclk_q <= 1'b0;
            cnt_q  <= div;
            st_q   <= ST_LOW;
          end else begin
            cnt_q <= cnt_q - DIV_W'(1);
          end
        end
        ST_LOW: begin
          if (cnt_done) begin
            lclk_q <= 1'b1;
            if (last_lane) begin
              st_q <= ST_IDLE;
            end else begin
              idx_q  <= idx_nxt;
              lane_q <= lanes[idx_nxt];
              cnt_q  <= div;
              st_q   <= ST_SETUP;
            end
          end else begin
            cnt_q <= cnt_q - DIV_W'(1);
          end
        end
        default: begin
          st_q   <= ST_IDLE;
          lclk_q <= 1'b1;
        end
      endcase
    end
  end

  assign word_pop = start;
  assign lane_o   = lane_q;
  assign lclk_o   = lclk_q;

endmodule

// File: rtl/lnk8_word_tx.sv
module lnk8_word_tx #(
  parameter int WORD_W = 32,
  parameter int LANE_W = 8,
  parameter int DEPTH  = 4,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_en,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              lnk_ack_i,
  output logic [LANE_W-1:0] lnk_data_o,
  output logic              lnk_data_oe,
  output logic              lnk_clk_o,
  output logic              lnk_clk_oe
);

  localparam int SYNC_STAGES = 2;

  logic              ack_ok;
  logic              buf_avail;
  logic [WORD_W-1:0] buf_word;
  logic              ser_start;
  logic              oe_q;

  lnk_sync2 #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b0)
  ) u_ack_sync (
    .clk (clk),
    .rst (rst),
    .d   (lnk_ack_i),
    .q   (ack_ok)
  );

  lnk_obuf #(
    .W     (WORD_W),
    .DEPTH (DEPTH)
  ) u_obuf (
    .clk      (clk),
    .rst      (rst),
    .wr_valid (in_valid),
    .wr_ready (in_ready),
    .wr_data  (in_data),
    .rd_avail (buf_avail),
    .rd_pop   (ser_start),
    .rd_data  (buf_word)
  );

  lnk_ser #(
    .WORD_W (WORD_W),
    .LANE_W (LANE_W),
    .DIV_W  (DIV_W)
  ) u_ser (
    .clk        (clk),
    .rst        (rst),
    .en         (cfg_en),
    .div        (cfg_div),
    .ack_ok     (ack_ok),
    .word_avail (buf_avail),
    .word_in    (buf_word),
    .word_pop   (ser_start),
    .lane_o     (lnk_data_o),
    .lclk_o     (lnk_clk_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q <= 1'b0;
    end else begin
      oe_q <= cfg_en;
    end
  end

  assign lnk_data_oe = oe_q;
  assign lnk_clk_oe  = oe_q;

endmodule

// File: rtl/lnk8_word_tx_chk.sv
module lnk8_word_tx_chk #(
  parameter int LANE_W = 8,
  parameter int DEPTH  = 4,
  parameter int DIV_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_en,
  input logic [DIV_W-1:0]  cfg_div,
  input logic              in_valid,
  input logic              in_ready,
  input logic              lnk_ack_i,
  input logic [LANE_W-1:0] lnk_data_o,
  input logic              lnk_data_oe,
  input logic              lnk_clk_o,
  input logic              lnk_clk_oe,
  input logic              word_start
);

  int occ_q;
  int lo_cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      occ_q <= 0;
    end else begin
      occ_q <= occ_q + ((in_valid && in_ready) ? 1 : 0) - (word_start ? 1 : 0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_cnt_q <= 0;
    end else if (!lnk_clk_o) begin
      lo_cnt_q <= lo_cnt_q + 1;
    end else begin
      lo_cnt_q <= 0;
    end
  end

  AST_PADS_OFF: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> (!lnk_data_oe && !lnk_clk_oe));  // R2
  AST_PADS_ON: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> (lnk_data_oe && lnk_clk_oe));  // R2
  AST_DATA_FROZEN_LOW: assert property (@(posedge clk) disable iff (rst)
    !lnk_clk_o |-> $stable(lnk_data_o));  // R3
  AST_LOW_PHASE_LEN: assert property (@(posedge clk) disable iff (rst)
    ($rose(lnk_clk_o) && lnk_clk_oe) |-> (lo_cnt_q == int'(cfg_div) + 1));  // R4
  AST_START_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    word_start |-> $past(lnk_ack_i, 2));  // R5
  AST_FULL_STALLS: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> (occ_q == DEPTH));  // R7
  AST_ROOM_ACCEPTS: assert property (@(posedge clk) disable iff (rst)
    (occ_q < DEPTH) |-> in_ready);  // R7

endmodule

bind lnk8_word_tx lnk8_word_tx_chk #(
  .LANE_W (LANE_W),
  .DEPTH  (DEPTH),
  .DIV_W  (DIV_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_en      (cfg_en),
  .cfg_div     (cfg_div),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .lnk_ack_i   (lnk_ack_i),
  .lnk_data_o  (lnk_data_o),
  .lnk_data_oe (lnk_data_oe),
  .lnk_clk_o   (lnk_clk_o),
  .lnk_clk_oe  (lnk_clk_oe),
  .word_start  (ser_start)
);

// File: tb/lnk8_word_tx_tb_top.sv
`timescale 1ns/1ps
module lnk8_word_tx_tb_top;

  localparam int WW = 32;
  localparam int LW = 8;
  localparam int DW = 8;
  localparam int NV = 6;
  // {cfg_div, word}
  localparam logic [39:0] VEC [NV] = '{
    {8'd0, 32'h0403_0201},
    {8'd1, 32'hDEAD_BEEF},
    {8'd2, 32'h8000_0001},
    {8'd0, 32'hFFFF_FFFF},
    {8'd3, 32'h0000_0000},
    {8'd5, 32'hA55A_3CC3}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_en = 1'b0;
  logic [DW-1:0] cfg_div = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [WW-1:0] in_data = '0;
  logic          lnk_ack_i = 1'b0;
  logic [LW-1:0] lnk_data_o;
  logic          lnk_data_oe, lnk_clk_o, lnk_clk_oe;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  lnk8_word_tx dut_i (
    .clk (clk), .rst (rst), .cfg_en (cfg_en), .cfg_div (cfg_div),
    .in_valid (in_valid), .in_ready (in_ready), .in_data (in_data),
    .lnk_ack_i (lnk_ack_i), .lnk_data_o (lnk_data_o),
    .lnk_data_oe (lnk_data_oe), .lnk_clk_o (lnk_clk_o), .lnk_clk_oe (lnk_clk_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // link monitor: bytes captured on falling strobe edges, low phase measured
  logic [7:0] cap [256];
  int   cap_n = 0;
  int   cyc = 0;
  int   fall_cyc = 0;
  logic clk_prev = 1'b1;

  always @(negedge clk) begin
    if (!rst && lnk_clk_oe && clk_prev && !lnk_clk_o) begin
      cap[cap_n % 256] = lnk_data_o;
      cap_n++;
      fall_cyc = cyc;
    end
    if (!rst && lnk_clk_oe && !clk_prev && lnk_clk_o) begin
      chk((cyc - fall_cyc) == int'(cfg_div) + 1, "R4 low phase length",
          64'(cyc - fall_cyc), 64'(int'(cfg_div) + 1));
    end
    clk_prev = lnk_clk_o;
    cyc++;
  end

  task automatic push(input logic [WW-1:0] w);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_cap(input int target, input int limit);
    int k = 0;
    while (cap_n < target && k < limit) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic chk_word(input int base, input logic [WW-1:0] w, input string req);
    for (int k = 0; k < 4; k++) begin
      chk(cap[(base + k) % 256] == w[8*k +: 8], req,
          64'(cap[(base + k) % 256]), 64'(w[8*k +: 8]));
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int base;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(in_ready == 1'b1, "R1 in_ready", 64'(in_ready), 64'd1);
    chk(lnk_clk_o == 1'b1, "R1 link clock", 64'(lnk_clk_o), 64'd1);
    chk(lnk_data_o == '0, "R1 data", 64'(lnk_data_o), 64'd0);
    chk({lnk_data_oe, lnk_clk_oe} == 2'b00, "R1 pad enables", 64'({lnk_data_oe, lnk_clk_oe}), 64'd0);

    // R2 enable drives pads
    cfg_en = 1'b1;
    @(negedge clk);
    chk({lnk_data_oe, lnk_clk_oe} == 2'b11, "R2 pads on", 64'({lnk_data_oe, lnk_clk_oe}), 64'd3);

    // table of words and dividers: R3 byte order, R4 timing
    lnk_ack_i = 1'b1;
    idle(4);
    for (int v = 0; v < NV; v++) begin
      cfg_div = VEC[v][39:32];
      base = cap_n;
      push(VEC[v][31:0]);
      wait_cap(base + 4, 500);
      idle(2 * (int'(cfg_div) + 2) + 4);
      chk(cap_n == base + 4, "R3 one fall per byte", 64'(cap_n - base), 64'd4);
      chk_word(base, VEC[v][31:0], "R3 byte order");
      chk(lnk_clk_o == 1'b1, "R4 idle high", 64'(lnk_clk_o), 64'd1);
    end

    // R7 back-to-back words keep order
    cfg_div = 8'd1;
    base = cap_n;
    push(32'h1122_3344);
    push(32'h5566_7788);
    wait_cap(base + 8, 500);
    idle(10);
    chk_word(base, 32'h1122_3344, "R7 order first");
    chk_word(base + 4, 32'h5566_7788, "R7 order second");

    // R5 stall while acknowledge low
    lnk_ack_i = 1'b0;
    idle(5);
    base = cap_n;
    push(32'hCAFE_0F0F);
    idle(80);
    chk(cap_n == base, "R5 held without ack", 64'(cap_n - base), 64'd0);
    chk(lnk_clk_o == 1'b1, "R5 clock rests high", 64'(lnk_clk_o), 64'd1);
    lnk_ack_i = 1'b1;
    wait_cap(base + 4, 500);
    idle(10);
    chk_word(base, 32'hCAFE_0F0F, "R5 sent after ack");

    // R6 ack drops mid-word
    cfg_div = 8'd3;
    base = cap_n;
    push(32'h0A0B_0C0D);
    push(32'h9988_7766);
    wait_cap(base + 1, 500);
    lnk_ack_i = 1'b0;
    idle(200);
    chk(cap_n == base + 4, "R6 word completes, next held", 64'(cap_n - base), 64'd4);
    chk_word(base, 32'h0A0B_0C0D, "R6 finished word");
    lnk_ack_i = 1'b1;
    wait_cap(base + 8, 500);
    idle(20);
    chk_word(base + 4, 32'h9988_7766, "R6 next word after ack");

    // R7 full buffer refuses extra word
    cfg_div = 8'd0;
    lnk_ack_i = 1'b0;
    idle(5);
    base = cap_n;
    for (int i = 0; i < 4; i++) push(32'h1000_0000 * (i + 1) + 32'(i));
    @(negedge clk);
    chk(in_ready == 1'b0, "R7 full", 64'(in_ready), 64'd0);
    in_valid = 1'b1;
    in_data  = 32'hBAD0_BAD0;
    idle(3);
    in_valid = 1'b0;
    lnk_ack_i = 1'b1;
    wait_cap(base + 16, 2000);
    idle(100);
    chk(cap_n == base + 16, "R7 refused word absent", 64'(cap_n - base), 64'd16);
    for (int i = 0; i < 4; i++) chk_word(base + 4 * i, 32'h1000_0000 * (i + 1) + 32'(i), "R7 fifo order");

    // R8 disable mid-word
    cfg_div = 8'd2;
    lnk_ack_i = 1'b0;
    idle(5);
    base = cap_n;
    push(32'hE1E2_E3E4);
    push(32'h7172_7374);
    lnk_ack_i = 1'b1;
    wait_cap(base + 1, 500);
    cfg_en = 1'b0;
    @(negedge clk);
    chk({lnk_data_oe, lnk_clk_oe} == 2'b00, "R2 pads off", 64'({lnk_data_oe, lnk_clk_oe}), 64'd0);
    idle(30);
    chk(cap_n == base + 1, "R8 abandoned word stops", 64'(cap_n - base), 64'd1);
    chk(cap[base % 256] == 8'hE4, "R8 first byte before stop", 64'(cap[base % 256]), 64'hE4);
    cfg_en = 1'b1;
    wait_cap(base + 5, 500);
    idle(60);
    chk(cap_n == base + 5, "R8 only buffered word follows", 64'(cap_n - base), 64'd5);
    chk_word(base + 1, 32'h7172_7374, "R8 buffered word kept");

    summary();
    $finish;
  end

endmodule